// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns a one-wire asynchronous serial stream into bytes. The line is passed through a synchronizer and can optionally be inverted. An external divider supplies a sampling tick at `OVS` times the bit rate. A falling edge arms start detection. The start bit is accepted only if the line is still low half a bit later. Every later bit is sampled at its centre, one full bit period after the previous sample. Each frame carries eight data bits, least significant bit first. An optional parity bit and one stop bit follow the data.

When a frame ends, the receiver loads the byte into a holding register. It then raises either a receive-complete pulse or an error pulse, with status flags for a framing error, a parity error or an overrun. If a byte that was never read is still held, the new byte is discarded. The receiver is ready for a new start edge as soon as the stop bit has been sampled, so frames can follow each other with no idle time between them.

Top module: `serial_rx_core`

## Requirements
- R1: A high-to-low change of the line arms start detection. If the line is low after `OVS/2` sampling ticks, a frame begins. If it is high, the receiver returns to idle with no busy flag and no pulse.
- R2: A line that is already low when `rx_en` rises is never taken as a start bit. Only a later high-to-low change can start a frame.
- R3: Data bits are sampled every `OVS` ticks after the start sample and are assembled least significant bit first. In a clean frame, `rx_data` takes the byte in the same cycle that `rx_done` pulses.
- R4: `par_mode` selects the parity: 2'b00 none, 2'b01 even, 2'b10 odd, 2'b11 none. When parity is selected, the bit after the data is the parity bit. A mismatch pulses `rx_err` with `err_parity`=1, and the byte is still loaded.
- R5: A low stop-bit sample pulses `rx_err` with `err_frame`=1, and the byte is still loaded.
- R6: `rx_valid` is set when a byte is loaded and cleared by `rd_strobe`. If a frame ends while `rx_valid`=1 and no read happens in that cycle, `rx_err` pulses with `err_overrun`=1. In that case `rx_data` and `rx_valid` are unchanged.
- R7: `rx_done` and `rx_err` each last one cycle, and they never assert together.
- R8: `rx_busy` rises when a start bit is accepted and falls in the cycle of the frame-end pulse. Only one stop bit is checked. A start edge directly after the stop bit is received, and any extra stop bit is treated as idle line.
- R9: With `rx_inv`=1, the receiver decodes the complement of the line.
- R10: Dropping `rx_en` abandons any frame in progress. `rx_busy` is clear by the next cycle, and the abandoned frame gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| rx_inv | input | 1 | Invert line level (change only while disabled) |
| par_mode | input | 2 | Parity selection (see R4) |
| os_tick | input | 1 | Sampling tick, OVS per bit period |
| rx_line | input | 1 | Asynchronous serial input |
| rd_strobe | input | 1 | Consumer has read `rx_data` |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Held byte not yet read |
| rx_busy | output | 1 | Frame in progress |
| rx_done | output | 1 | One-cycle clean-frame pulse |
| rx_err | output | 1 | One-cycle errored-frame pulse |
| err_frame | output | 1 | Last frame had a low stop bit |
| err_parity | output | 1 | Last frame had a parity mismatch |
| err_overrun | output | 1 | Last frame was dropped as an overrun |

## Verification
The bench sends every byte value, and for each parity type it sends bytes with both correct and wrong parity bits. A design that sampled at bit edges, shifted most significant bit first, or inverted the odd/even sense would load the wrong byte or raise the wrong flag. A short low glitch and a line held low at enable are both sent. A receiver that skipped the half-bit recheck, or that compared against a preset idle level, would start a phantom frame. An overrun is forced by leaving a byte unread. A design that overwrote the held byte or raised the complete pulse in that case would be caught. Frames are also sent back to back, with one stop bit and with two, along with an inverted line and a frame cut short by disabling the receiver. These catch a receiver that waits for a full stop bit, that misreads the second stop bit as a new start, or that still reports a frame it has abandoned.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam logic [1:0] PM_EVEN = 2'b01;
  localparam logic [1:0] PM_ODD  = 2'b10;

  typedef struct packed {
    logic frame;
    logic parity;
    logic overrun;
  } rx_flags_t;

  function automatic logic parity_on(input logic [1:0] mode);
    return (mode == PM_EVEN) || (mode == PM_ODD);
  endfunction

  // ones_odd: XOR over data bits and the received parity bit
  function automatic logic parity_wrong(input logic [1:0] mode, input logic ones_odd);
    if (mode == PM_EVEN) return ones_odd;
    if (mode == PM_ODD)  return ~ones_odd;
    return 1'b0;
  endfunction

endpackage

// File: rtl/srx_line_front.sv
module srx_line_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic inv_i,
  input  logic line_i,
  output logic lvl_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES:0]   warm_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      warm_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      warm_q <= {warm_q[SYNC_STAGES-1:0], 1'b1};
      prev_q <= lvl_o;
    end
  end

  // Level after the synchronizer, then polarity applied.
  assign lvl_o  = sync_q[SYNC_STAGES-1] ^ inv_i;
  // Edge needs a real high seen earlier: a low held at enable never qualifies.
  assign fall_o = en_i & warm_q[SYNC_STAGES] & prev_q & ~lvl_o;
endmodule

// File: rtl/srx_bit_clock.sv
module srx_bit_clock #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic half_i,
  input  logic tick_i,
  output logic hit_o
);
  localparam int CNT_W = (OVS > 2) ? $clog2(OVS) : 1;
  localparam int HALF  = OVS / 2;
  localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] LIM_FULL = CNT_W'(OVS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim   = half_i ? LIM_HALF : LIM_FULL;
  assign hit_o = tick_i & ~clr_i & (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (hit_o) cnt_q <= '0;
      else       cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/srx_frame_ctrl.sv
module srx_frame_ctrl
  import srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [1:0]        par_mode_i,
  input  logic              lvl_i,
  input  logic              fall_i,
  input  logic              hit_i,
  output logic              tmr_clr_o,
  output logic              tmr_half_o,
  output logic              busy_o,
  output logic              end_o,
  output logic [DATA_W-1:0] word_o,
  output logic              fe_o,
  output logic              pe_o
);
  localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              pacc_q;
  logic              busy_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      pacc_q  <= 1'b0;
      busy_q  <= 1'b0;
      if (rst) shreg_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (fall_i) state_q <= ST_START;
        end
        ST_START: begin
          if (hit_i) begin
            if (!lvl_i) begin
              state_q <= ST_DATA;
              busy_q  <= 1'b1;
              idx_q   <= '0;
              pacc_q  <= 1'b0;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_DATA: begin
          if (hit_i) begin
            shreg_q <= {lvl_i, shreg_q[DATA_W-1:1]};
            pacc_q  <= pacc_q ^ lvl_i;
            if (idx_q == LAST_IDX) begin
              state_q <= parity_on(par_mode_i) ? ST_PAR : ST_STOP;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (hit_i) begin
            pacc_q  <= pacc_q ^ lvl_i;
            state_q <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (hit_i) begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tmr_clr_o  = (state_q == ST_IDLE);
  assign tmr_half_o = (state_q == ST_START);
  assign busy_o     = busy_q;
  assign end_o      = (state_q == ST_STOP) & hit_i;
  assign word_o     = shreg_q;
  assign fe_o       = ~lvl_i;
  assign pe_o       = parity_wrong(par_mode_i, pacc_q);
endmodule

// File: rtl/srx_result_reg.sv
module srx_result_reg
  import srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              end_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              fe_i,
  input  logic              pe_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              done_o,
  output logic              err_o,
  output rx_flags_t         flags_o
);
  logic ovr;
  assign ovr = valid_o & ~rd_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      flags_o <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (rd_i) valid_o <= 1'b0;
      if (end_i) begin
        flags_o <= '{frame: fe_i, parity: pe_i, overrun: ovr};
        if (ovr) begin
          err_o <= 1'b1;
        end else begin
          data_o  <= word_i;
          valid_o <= 1'b1;
          if (fe_i || pe_i) err_o  <= 1'b1;
          else              done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              rx_inv,
  input  logic [1:0]        par_mode,
  input  logic              os_tick,
  input  logic              rx_line,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_busy,
  output logic              rx_done,
  output logic              rx_err,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun
);
  logic              lvl, fall, hit, tmr_clr, tmr_half, frame_end, fe, pe;
  logic [DATA_W-1:0] word;
  rx_flags_t         flags;

  srx_line_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .en_i(rx_en), .inv_i(rx_inv),
    .line_i(rx_line), .lvl_o(lvl), .fall_o(fall)
  );

  srx_bit_clock #(.OVS(OVS)) u_clock (
    .clk(clk), .rst(rst), .clr_i(tmr_clr), .half_i(tmr_half),
    .tick_i(os_tick), .hit_o(hit)
  );

  srx_frame_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .en_i(rx_en), .par_mode_i(par_mode),
    .lvl_i(lvl), .fall_i(fall), .hit_i(hit),
    .tmr_clr_o(tmr_clr), .tmr_half_o(tmr_half), .busy_o(rx_busy),
    .end_o(frame_end), .word_o(word), .fe_o(fe), .pe_o(pe)
  );

  srx_result_reg #(.DATA_W(DATA_W)) u_result (
    .clk(clk), .rst(rst), .end_i(frame_end), .word_i(word),
    .fe_i(fe), .pe_i(pe), .rd_i(rd_strobe),
    .data_o(rx_data), .valid_o(rx_valid), .done_o(rx_done),
    .err_o(rx_err), .flags_o(flags)
  );

  assign err_frame   = flags.frame;
  assign err_parity  = flags.parity;
  assign err_overrun = flags.overrun;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_en,
  input logic              rd_strobe,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_busy,
  input logic              rx_done,
  input logic              rx_err,
  input logic              err_overrun
);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rx_done && rx_err));

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done);

  a_r7_err_single: assert property (@(posedge clk) disable iff (rst)
    rx_err |=> !rx_err);

  a_r3_data_only_on_load: assert property (@(posedge clk) disable iff (rst)
    (!rx_done && !(rx_err && !err_overrun)) |-> $stable(rx_data));

  a_r6_overrun_keeps: assert property (@(posedge clk) disable iff (rst)
    (rx_err && err_overrun) |-> ($stable(rx_data) && rx_valid));

  a_r6_load_sets_valid: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> rx_valid);

  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> (!rx_valid || rx_done || rx_err));

  a_r8_idle_at_end: assert property (@(posedge clk) disable iff (rst)
    (rx_done || rx_err) |-> !rx_busy);

  a_r8_busy_ends_with_pulse: assert property (@(posedge clk) disable iff (rst)
    ($fell(rx_busy) && $past(rx_en)) |-> (rx_done || rx_err));

  a_r10_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !rx_busy);
endmodule

bind serial_rx_core srx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .rd_strobe(rd_strobe),
  .rx_data(rx_data), .rx_valid(rx_valid), .rx_busy(rx_busy),
  .rx_done(rx_done), .rx_err(rx_err), .err_overrun(err_overrun)
);

// File: tb/sim_serial_rx_core.sv
module sim_serial_rx_core;
  localparam int OVS      = 8;
  localparam int TICK_DIV = 2;
  localparam int BITCLK   = OVS * TICK_DIV;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1, rx_en = 1'b0, rx_inv = 1'b0, os_tick = 1'b0;
  logic       rx_line = 1'b1, rd_strobe = 1'b0;
  logic [1:0] par_mode = 2'b00;
  logic [7:0] rx_data;
  logic       rx_valid, rx_busy, rx_done, rx_err, err_frame, err_parity, err_overrun;

  serial_rx_core #(.DATA_W(8), .OVS(OVS), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_inv(rx_inv), .par_mode(par_mode),
    .os_tick(os_tick), .rx_line(rx_line), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_busy(rx_busy),
    .rx_done(rx_done), .rx_err(rx_err), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun)
  );

  int tcnt = 0;
  always @(posedge clk) begin
    if (rst) begin
      tcnt    <= 0;
      os_tick <= 1'b0;
    end else begin
      tcnt    <= (tcnt == TICK_DIV - 1) ? 0 : tcnt + 1;
      os_tick <= (tcnt == TICK_DIV - 1);
    end
  end

  // Event log: {done, err, frame, parity, overrun, data}
  logic [12:0] ev_rec [0:1023];
  int ev_n = 0;
  always @(negedge clk) begin
    if (!rst && (rx_done || rx_err)) begin
      if (ev_n < 1024)
        ev_rec[ev_n] = {rx_done, rx_err, err_frame, err_parity, err_overrun, rx_data};
      ev_n = ev_n + 1;
    end
  end

  int  vectors = 0, miscompares = 0;
  bit  tb_inv = 1'b0;
  bit  busy_mid;
  bit  finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    rx_line = v ^ tb_inv;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'b1);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic [1:0] pm, input bit flip,
                            input logic stop_v, input int n_stop);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) begin
      drive_bit(b[i]);
      if (i == 1) busy_mid = rx_busy;
    end
    if (pm == 2'b01) drive_bit((^b) ^ flip);
    if (pm == 2'b10) drive_bit((~^b) ^ flip);
    drive_bit(stop_v);
    for (int i = 1; i < n_stop; i++) drive_bit(1'b1);
  endtask

  task automatic do_read;
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  function automatic logic [12:0] rec(input bit d, input bit e, input bit f,
                                      input bit p, input bit o, input logic [7:0] b);
    return {d, e, f, p, o, b};
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : main
    int base;
    repeat (4) @(negedge clk);
    // R2: line held low before enable
    rx_line = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("reset rx_data", rx_data, 0);
    chk("reset rx_valid", rx_valid, 0);
    chk("reset rx_busy", rx_busy, 0);
    chk("reset rx_done", rx_done, 0);
    chk("reset rx_err", rx_err, 0);
    repeat (10) @(negedge clk);
    base = ev_n;
    rx_en = 1'b1;
    repeat (80) @(negedge clk);
    chk("R2 busy with low at enable", rx_busy, 0);
    rx_line = 1'b1;
    repeat (40) @(negedge clk);
    chk("R2 no event from low at enable", ev_n - base, 0);

    // R1: short low glitch rejected by half-bit recheck
    base = ev_n;
    rx_line = 1'b0;
    repeat (4) @(negedge clk);
    rx_line = 1'b1;
    repeat (60) @(negedge clk);
    chk("R1 glitch busy", rx_busy, 0);
    chk("R1 glitch no event", ev_n - base, 0);

    // R3: every byte value, no parity
    for (int b = 0; b < 256; b++) begin
      base = ev_n;
      send_frame(8'(b), 2'b00, 1'b0, 1'b1, 1);
      chk("R8 busy mid-frame", busy_mid, 1);
      chk("R8 busy clear after stop", rx_busy, 0);
      chk("R3 event count", ev_n - base, 1);
      chk("R3 clean frame", ev_rec[base], rec(1, 0, 0, 0, 0, 8'(b)));
      chk("R6 valid after load", rx_valid, 1);
      do_read();
      chk("R6 read clears valid", rx_valid, 0);
      idle_bits(1);
    end

    // R4: even and odd parity, good and bad
    for (int pm = 1; pm <= 2; pm++) begin
      par_mode = 2'(pm);
      for (int k = 0; k < 32; k++) begin
        logic [7:0] b;
        bit flip;
        b    = 8'(k * 8 + 3 + pm);
        flip = k[0];
        base = ev_n;
        send_frame(b, 2'(pm), flip, 1'b1, 1);
        chk("R4 event count", ev_n - base, 1);
        chk("R4 parity result", ev_rec[base], rec(!flip, flip, 0, flip, 0, b));
        do_read();
        idle_bits(1);
      end
    end

    // R4: mode 2'b11 behaves as no parity
    par_mode = 2'b11;
    for (int k = 0; k < 4; k++) begin
      base = ev_n;
      send_frame(8'(8'h81 + k * 16), 2'b00, 1'b0, 1'b1, 1);
      chk("R4 mode 11 no parity", ev_rec[base], rec(1, 0, 0, 0, 0, 8'(8'h81 + k * 16)));
      do_read();
      idle_bits(1);
    end
    par_mode = 2'b00;

    // R5: framing error still loads data
    for (int k = 0; k < 3; k++) begin
      logic [7:0] b;
      b = (k == 0) ? 8'h00 : (k == 1) ? 8'h5A : 8'hFF;
      base = ev_n;
      send_frame(b, 2'b00, 1'b0, 1'b0, 1);
      idle_bits(2);
      chk("R5 event count", ev_n - base, 1);
      chk("R5 framing result", ev_rec[base], rec(0, 1, 1, 0, 0, b));
      chk("R5 data loaded", rx_data, b);
      do_read();
    end

    // R6: overrun
    base = ev_n;
    send_frame(8'h11, 2'b00, 1'b0, 1'b1, 1);
    idle_bits(1);
    chk("R6 first frame", ev_rec[base], rec(1, 0, 0, 0, 0, 8'h11));
    send_frame(8'h22, 2'b00, 1'b0, 1'b1, 1);
    idle_bits(1);
    chk("R6 overrun event", ev_rec[base + 1], rec(0, 1, 0, 0, 1, 8'h11));
    chk("R6 data kept", rx_data, 8'h11);
    chk("R6 valid kept", rx_valid, 1);
    do_read();
    chk("R6 valid cleared", rx_valid, 0);
    base = ev_n;
    send_frame(8'h33, 2'b00, 1'b0, 1'b1, 1);
    idle_bits(1);
    chk("R6 recovery", ev_rec[base], rec(1, 0, 0, 0, 0, 8'h33));
    do_read();

    // R8: back to back, one stop bit then two stop bits
    base = ev_n;
    rd_strobe = 1'b1;
    send_frame(8'hC3, 2'b00, 1'b0, 1'b1, 1);
    send_frame(8'h3C, 2'b00, 1'b0, 1'b1, 2);
    send_frame(8'h96, 2'b00, 1'b0, 1'b1, 1);
    rd_strobe = 1'b0;
    idle_bits(1);
    chk("R8 back-to-back count", ev_n - base, 3);
    chk("R8 b2b frame 1", ev_rec[base], rec(1, 0, 0, 0, 0, 8'hC3));
    chk("R8 b2b frame 2", ev_rec[base + 1], rec(1, 0, 0, 0, 0, 8'h3C));
    chk("R8 b2b frame 3", ev_rec[base + 2], rec(1, 0, 0, 0, 0, 8'h96));
    do_read();

    // R9: inverted line
    rx_en = 1'b0;
    tb_inv = 1'b1;
    rx_inv = 1'b1;
    rx_line = 1'b0;
    repeat (8) @(negedge clk);
    rx_en = 1'b1;
    repeat (8) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      logic [7:0] b;
      b = (k == 0) ? 8'hA5 : (k == 1) ? 8'h3C : 8'h01;
      base = ev_n;
      send_frame(b, 2'b00, 1'b0, 1'b1, 1);
      idle_bits(1);
      chk("R9 inverted frame", ev_rec[base], rec(1, 0, 0, 0, 0, b));
      do_read();
    end
    rx_en = 1'b0;
    tb_inv = 1'b0;
    rx_inv = 1'b0;
    rx_line = 1'b1;
    repeat (8) @(negedge clk);
    rx_en = 1'b1;
    repeat (8) @(negedge clk);

    // R10: disable mid-frame
    base = ev_n;
    drive_bit(1'b0);
    drive_bit(1'b1);
    drive_bit(1'b0);
    chk("R10 busy before disable", rx_busy, 1);
    rx_en = 1'b0;
    @(negedge clk);
    chk("R10 busy cleared", rx_busy, 0);
    rx_line = 1'b1;
    repeat (BITCLK * 10) @(negedge clk);
    chk("R10 no event", ev_n - base, 0);
    rx_en = 1'b1;
    repeat (8) @(negedge clk);
    send_frame(8'h7E, 2'b00, 1'b0, 1'b1, 1);
    idle_bits(1);
    chk("R10 recovery frame", ev_rec[base], rec(1, 0, 0, 0, 0, 8'h7E));

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule